// File: doc/BRIEF.md
# Key-Cleared Watchdog Timer

This block is the watchdog of a small microcontroller. It counts ticks of a free-running, oscillator-derived enable and, if software lets the count run for the full timeout, raises a single-cycle reset request toward the chip's reset generator. The reset generator stretches that request into a full chip reset; the stretching is not part of this block.

Software keeps the chip alive by writing one exact key byte to one dedicated address on the byte-wide peripheral write bus. Any other value, any other address, or a bus cycle without the write strobe leaves the count untouched. The clear location is write-only and no bit or write sequence turns the watchdog off. After every chip reset the count starts from zero and is already running. The timeout is a parameter counted in watchdog ticks. Its default is about 0.175 s at a 32.768 kHz tick.

Top module: `wdt_guard`

## Requirements
- R1: While the chip reset is asserted and after it is released, `rst_req` is low, and a request needs a full `TIMEOUT_TICKS` ticks counted after release.
- R2: `rst_req` goes high for exactly one clock cycle, in the cycle after the clock edge that samples the `TIMEOUT_TICKS`-th tick since the last restart.
- R3: After raising a request the count restarts from zero, so the next request follows after another `TIMEOUT_TICKS` ticks.
- R4: A bus write with `bus_we` = 1, `bus_addr` = 0xCA and `bus_wdata` = 0x55 restarts the count from zero, whatever its value was.
- R5: A write to 0xCA with any data value other than 0x55 is ignored and does not restart or advance the count.
- R6: A write to any address other than 0xCA, including data 0x55, is ignored.
- R7: Address 0xCA with data 0x55 but `bus_we` = 0 is ignored.
- R8: When a key write and a tick arrive in the same cycle, the restart wins and that tick is not counted.
- R9: While `rst_n` is low the count is held at zero and no request is raised, however many ticks arrive.
- R10: Clock cycles with `tick` = 0 leave the count unchanged, so only ticks advance it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Chip reset, active low. It asserts asynchronously and is released synchronously inside the block |
| tick | input | 1 | One-cycle enable from the watchdog oscillator divider |
| bus_addr | input | ADDR_W | Peripheral write address |
| bus_wdata | input | DATA_W | Peripheral write data |
| bus_we | input | 1 | Peripheral write strobe |
| rst_req | output | 1 | One-cycle reset request to the reset generator |

## Verification
The bench uses an eight-tick timeout. It places the key write at every possible count position and checks that each position restarts a full interval. It sweeps all 255 wrong data values at the key address and all 255 other addresses with the key value, each issued one tick before expiry. This separates a decode that checks the address alone, or the data alone, from one that needs both. Further runs place the ticks with idle gaps between them, put a key write in the same cycle as the final tick, and assert reset in the middle of a count. Together these tell apart counting on the clock from counting on the tick, restart priority over the tick, and a restart from zero after reset from a count that resumes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Default geometry of the peripheral write bus.
  localparam int unsigned WDT_ADDR_W = 8;
  localparam int unsigned WDT_DATA_W = 8;
  // Clear location and the key byte that restarts the count.
  localparam logic [WDT_ADDR_W-1:0] WDT_KEY_ADDR = 8'hCA;
  localparam logic [WDT_DATA_W-1:0] WDT_KEY_VAL  = 8'h55;
  // About 0.175 s at a 32.768 kHz tick.
  localparam int unsigned WDT_TIMEOUT_DEF = 5734;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_key_match.sv
module wdt_key_match #(
  parameter int unsigned     ADDR_W   = 8,
  parameter int unsigned     DATA_W   = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = '0,
  parameter logic [DATA_W-1:0] KEY_VAL  = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              we_i,
  output logic              clear_o
);
  logic addr_hit;
  logic data_hit;

  always_comb begin
    addr_hit = (addr_i == KEY_ADDR);
    data_hit = (data_i == KEY_VAL);
    clear_o  = we_i & addr_hit & data_hit;
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned TIMEOUT_TICKS = 8,
  localparam int unsigned CNT_W = (TIMEOUT_TICKS < 2) ? 1 : $clog2(TIMEOUT_TICKS)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire_q, fire_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear_i | tick_i;
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      fire_q <= fire_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire_q;

  // R2: the count never passes the last position before expiry
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R2: a request lasts one cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    fire_q |=> !fire_q);

  // R3: the count is back at zero when the request is raised
  p_restart_after_fire_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    fire_q |-> (cnt_q == '0));

  // R4: a restart leaves zero in the count
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0) && !fire_q);

  // R10: no tick and no restart leave the count alone
  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int unsigned       TIMEOUT_TICKS = WDT_TIMEOUT_DEF,
  parameter int unsigned       ADDR_W        = WDT_ADDR_W,
  parameter int unsigned       DATA_W        = WDT_DATA_W,
  parameter logic [ADDR_W-1:0] KEY_ADDR      = WDT_KEY_ADDR,
  parameter logic [DATA_W-1:0] KEY_VAL       = WDT_KEY_VAL,
  parameter int unsigned       SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic              rst_req
);
  localparam int unsigned CNT_W = (TIMEOUT_TICKS < 2) ? 1 : $clog2(TIMEOUT_TICKS);

  logic             rst_sync_n;
  logic             key_clear;
  logic [CNT_W-1:0] cnt;

  wdt_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  wdt_key_match #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KEY_ADDR (KEY_ADDR),
    .KEY_VAL  (KEY_VAL)
  ) u_key_match (
    .addr_i  (bus_addr),
    .data_i  (bus_wdata),
    .we_i    (bus_we),
    .clear_o (key_clear)
  );

  wdt_count #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_count (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .tick_i  (tick),
    .clear_i (key_clear),
    .cnt_o   (cnt),
    .fire_o  (rst_req)
  );

  // R1: the watchdog leaves reset at zero and quiet
  p_zero_on_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (cnt == '0) && !rst_req);

  // R9: while the internal reset is held, the count stays at zero
  p_held_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (cnt == '0) && !rst_req);

  // R5: a wrong byte at the clear address changes nothing
  p_wrong_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == KEY_ADDR && bus_wdata != KEY_VAL && !tick) |=> $stable(cnt));

  // R6: other addresses change nothing
  p_other_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != KEY_ADDR && !tick) |=> $stable(cnt));

  // R7: without the strobe nothing changes
  p_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !tick) |=> $stable(cnt));

  // R8: a restart together with a tick still yields zero and no request
  p_clear_beats_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && bus_we && bus_addr == KEY_ADDR && bus_wdata == KEY_VAL && tick)
      |=> (cnt == '0) && !rst_req);
endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
  localparam int unsigned N = 8;
  localparam logic [7:0] KA = 8'hCA;
  localparam logic [7:0] KV = 8'h55;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic       rst_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdt_guard #(
    .TIMEOUT_TICKS (N)
  ) u_wdt_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .rst_req   (rst_req)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s rst_req actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // one tick, output sampled at the following falling edge
  task automatic tick1(input logic exp, input string req);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(rst_req, exp, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic we, input string req);
    bus_addr = a; bus_wdata = d; bus_we = we;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    chk(rst_req, 1'b0, req);
  endtask

  // from a zero count: N-1 quiet ticks, the N-th raises one pulse
  task automatic run_full(input string req);
    for (int i = 0; i < N - 1; i++) tick1(1'b0, req);
    tick1(1'b1, req);
    cyc();
    chk(rst_req, 1'b0, req);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) cyc();
    chk(rst_req, 1'b0, "R1");
    // R9: ticks during reset do nothing
    for (int i = 0; i < N + 2; i++) tick1(1'b0, "R9");
    rst_n = 1'b1;
    repeat (3) cyc();
    chk(rst_req, 1'b0, "R1");
    run_full("R1");
    // R2 and R3: repeated expiry, each after a full interval
    run_full("R2");
    run_full("R3");
    // R10: ticks spread with idle cycles between them
    for (int i = 0; i < N - 1; i++) begin
      tick1(1'b0, "R10");
      repeat (i % 3 + 1) begin cyc(); chk(rst_req, 1'b0, "R10"); end
    end
    tick1(1'b1, "R10");
    cyc();
    chk(rst_req, 1'b0, "R10");
    // R4: key write at every count position
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < k; i++) tick1(1'b0, "R4");
      wr(KA, KV, 1'b1, "R4");
      run_full("R4");
    end
    // R8: key write together with the final tick
    for (int i = 0; i < N - 1; i++) tick1(1'b0, "R8");
    bus_addr = KA; bus_wdata = KV; bus_we = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
    chk(rst_req, 1'b0, "R8");
    run_full("R8");
    // R5: every wrong byte at the clear address
    for (int d = 0; d < 256; d++) begin
      if (d[7:0] == KV) continue;
      for (int i = 0; i < N - 1; i++) tick1(1'b0, "R5");
      wr(KA, d[7:0], 1'b1, "R5");
      tick1(1'b1, "R5");
      cyc();
      chk(rst_req, 1'b0, "R5");
    end
    // R6: key value at every other address
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] == KA) continue;
      for (int i = 0; i < N - 1; i++) tick1(1'b0, "R6");
      wr(a[7:0], KV, 1'b1, "R6");
      tick1(1'b1, "R6");
      cyc();
      chk(rst_req, 1'b0, "R6");
    end
    // R7: key address and value without the strobe
    for (int i = 0; i < N - 1; i++) tick1(1'b0, "R7");
    wr(KA, KV, 1'b0, "R7");
    tick1(1'b1, "R7");
    cyc();
    chk(rst_req, 1'b0, "R7");
    // R9: reset in the middle of a count restarts from zero
    for (int i = 0; i < N - 1; i++) tick1(1'b0, "R9");
    rst_n = 1'b0;
    cyc();
    for (int i = 0; i < N + 2; i++) tick1(1'b0, "R9");
    rst_n = 1'b1;
    repeat (3) cyc();
    chk(rst_req, 1'b0, "R9");
    run_full("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule